// File: doc/BRIEF.md
# NIC Interrupt and Collision Status Unit

This block keeps two of the host-visible status registers of a small Ethernet controller. The first is an 8-bit interrupt status register. It holds a power-on/wake indicator and seven sticky event flags. The second is a 4-bit collision tally for the transmit attempt in progress.

The transmit path, the receive path, the remote-DMA engine, the tally counters and the buffer ring manager each signal events to the block as single-cycle pulses. The tally counters are the one exception: they report the level of each counter's top bit, and the block detects the rising edge. The block latches each event into its flag. The host clears a flag by writing a one to its bit position.

The host uses an 8-bit port with a one-bit register select. Address 0 selects the status register and address 1 selects the collision tally. A start-command strobe and a transmit-command strobe come from the command logic. A masked interrupt request is formed from the seven event flags and a per-bit enable input.

Top module: `nic_irq_status`

## Requirements
- R1: After reset, address 0 reads 0x80, address 1 reads 0x00 and `irq_o` is low.
- R2: Status bit 7 sets one cycle after `wake_i` and clears one cycle after `start_cmd_i`. When both strobes fall in the same cycle, the bit ends up set.
- R3: Host writes to address 0 never change status bit 7, whether the written bit 7 is 0 or 1.
- R4: Status bits 6..0 are sticky. A host write to address 0 clears each bit written as 1 and leaves each bit written as 0 unchanged. The bit map is: 6 remote DMA done, 5 counter overflow, 4 ring overwrite, 3 transmit error, 2 receive error, 1 transmit ok, 0 receive ok.
- R5: When an event and a host clear of the same bit fall in the same cycle, the bit stays set. Other bits cleared by the same write still clear.
- R6: Bit 5 sets when any bit of `tally_msb_i` goes from 0 to 1. A top bit that stays high does not set bit 5 again after the host clears it.
- R7: Bit 3 sets on any of excessive collisions, oversize transmit or late collision. Bit 2 sets on any of CRC error, alignment error or missed packet.
- R8: Address 1 reads the collision count in bits 3:0, with bits 7:4 always zero. Each `col_i` pulse adds one to the count, and the count holds at 15.
- R9: An excessive-collision abort (`tx_excess_col_i`) sets the collision count to 0.
- R10: `tx_cmd_i` sets the collision count to 0. Host writes to address 1 have no effect.
- R11: `irq_o` is high exactly when some status bit in 6..0 is set together with the matching bit of `irq_en_i`. Bit 7 never raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr_i | input | 1 | Register select: 0 status, 1 collision count |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Read data for the selected register |
| start_cmd_i | input | 1 | Start command strobe |
| tx_cmd_i | input | 1 | Transmit command strobe |
| wake_i | input | 1 | Wake-up event |
| rdma_done_i | input | 1 | Remote DMA complete pulse |
| tally_msb_i | input | 3 | Top bit of each tally counter (level) |
| ring_ovw_i | input | 1 | Receive ring exhausted pulse |
| tx_excess_col_i | input | 1 | Transmit aborted: excessive collisions |
| tx_oversize_i | input | 1 | Transmit oversize error |
| tx_late_col_i | input | 1 | Late collision error |
| rx_crc_err_i | input | 1 | CRC error |
| rx_align_err_i | input | 1 | Frame alignment error |
| rx_missed_i | input | 1 | Missed packet |
| tx_ok_i | input | 1 | Packet sent without error |
| rx_ok_i | input | 1 | Packet received without error |
| col_i | input | 1 | One collision seen |
| irq_en_i | input | 7 | Interrupt enable per bit 6..0 |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Three pairs of actions can land in the same cycle, and each pair is tested. A hardware event and a host write-one-to-clear of the same flag can coincide. The bench drives an event pulse on the same edge as a write that clears both that flag and a second one. It passes only if the target flag survives and the other flag clears. The wake strobe and the start command are made to coincide, and the reset bit must end up set. A collision pulse is also issued together with an excessive-collision abort, and the collision count must read zero.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
    localparam int FLAG_N = 7;
    localparam int REG_W  = 8;

    localparam int B_RDC = 6;
    localparam int B_CNT = 5;
    localparam int B_OVW = 4;
    localparam int B_TXE = 3;
    localparam int B_RXE = 2;
    localparam int B_PTX = 1;
    localparam int B_PRX = 0;

    typedef struct packed {
        logic              rst;
        logic [FLAG_N-1:0] flags;
    } isr_t;

    localparam isr_t ISR_RESET = '{rst: 1'b1, flags: '0};
endpackage

// File: rtl/nic_isr_core.sv
module nic_isr_core
    import nic_irq_pkg::*;
#(
    parameter int NTALLY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_i,
    input  logic              start_i,
    input  logic [FLAG_N-1:0] evt_i,
    input  logic [FLAG_N-1:0] clr_i,
    input  logic [NTALLY-1:0] tally_msb_i,
    output isr_t              isr_o
);
    typedef struct packed {
        isr_t              isr;
        logic [NTALLY-1:0] msb;
    } st_t;

    st_t st_d, st_q;
    logic [NTALLY-1:0] msb_rise;
    logic [FLAG_N-1:0] set_all;
    logic [FLAG_N-1:0] flag_nx;

    assign msb_rise = tally_msb_i & ~st_q.msb;

    always_comb begin
        set_all        = evt_i;
        set_all[B_CNT] = evt_i[B_CNT] | (|msb_rise);
    end

    // set has priority over a same-cycle clear
    for (genvar k = 0; k < FLAG_N; k++) begin : g_flag
        assign flag_nx[k] = set_all[k] | (st_q.isr.flags[k] & ~clr_i[k]);
    end

    always_comb begin
        st_d           = st_q;
        st_d.msb       = tally_msb_i;
        st_d.isr.flags = flag_nx;
        if (wake_i)       st_d.isr.rst = 1'b1;
        else if (start_i) st_d.isr.rst = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{isr: ISR_RESET, msb: '0};
        else        st_q <= st_d;
    end

    assign isr_o = st_q.isr;

    // R3
    rst_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_i && !start_i) |=> $stable(isr_o.rst));

    // R2
    rst_bit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !wake_i) |=> !isr_o.rst);

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((isr_o.flags & $past(evt_i)) == $past(evt_i)));

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~evt_i) != '0 && msb_rise == '0)
        |=> ((isr_o.flags & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/nic_col_counter.sv
module nic_col_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          col_i,
    input  logic          abort_i,
    input  logic          clear_i,
    output logic [CW-1:0] count_o
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i || abort_i)
            st_d.cnt = '0;
        else if (col_i && st_q.cnt != CMAX)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    // R8
    col_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CMAX && !clear_i && !abort_i) |=> (count_o == CMAX));

    // R8
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_i && !clear_i && !abort_i && count_o != CMAX)
        |=> (count_o == $past(count_o) + 1'b1));

    // R9
    col_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (count_o == '0));

    // R10
    col_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_o == '0));
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
    import nic_irq_pkg::*;
#(
    parameter int NTALLY = 3,
    parameter int COL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_addr_i,
    input  logic              host_wr_i,
    input  logic [7:0]        host_wdata_i,
    output logic [7:0]        host_rdata_o,
    input  logic              start_cmd_i,
    input  logic              tx_cmd_i,
    input  logic              wake_i,
    input  logic              rdma_done_i,
    input  logic [NTALLY-1:0] tally_msb_i,
    input  logic              ring_ovw_i,
    input  logic              tx_excess_col_i,
    input  logic              tx_oversize_i,
    input  logic              tx_late_col_i,
    input  logic              rx_crc_err_i,
    input  logic              rx_align_err_i,
    input  logic              rx_missed_i,
    input  logic              tx_ok_i,
    input  logic              rx_ok_i,
    input  logic              col_i,
    input  logic [6:0]        irq_en_i,
    output logic              irq_o
);
    localparam logic SEL_ISR = 1'b0;
    localparam logic SEL_COL = 1'b1;

    logic [FLAG_N-1:0] evt;
    logic [FLAG_N-1:0] clr;
    logic [FLAG_N-1:0] masked;
    logic [COL_W-1:0]  col_cnt;
    isr_t              isr;

    always_comb begin
        evt        = '0;
        evt[B_RDC] = rdma_done_i;
        evt[B_OVW] = ring_ovw_i;
        evt[B_TXE] = tx_excess_col_i | tx_oversize_i | tx_late_col_i;
        evt[B_RXE] = rx_crc_err_i | rx_align_err_i | rx_missed_i;
        evt[B_PTX] = tx_ok_i;
        evt[B_PRX] = rx_ok_i;
    end

    assign clr = (host_wr_i && host_addr_i == SEL_ISR) ? host_wdata_i[FLAG_N-1:0] : '0;

    nic_isr_core #(.NTALLY(NTALLY)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_i      (wake_i),
        .start_i     (start_cmd_i),
        .evt_i       (evt),
        .clr_i       (clr),
        .tally_msb_i (tally_msb_i),
        .isr_o       (isr)
    );

    nic_col_counter #(.CW(COL_W)) u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .col_i   (col_i),
        .abort_i (tx_excess_col_i),
        .clear_i (tx_cmd_i),
        .count_o (col_cnt)
    );

    always_comb begin
        host_rdata_o = '0;
        if (host_addr_i == SEL_COL)
            host_rdata_o[COL_W-1:0] = col_cnt;
        else
            host_rdata_o = isr;
    end

    for (genvar k = 0; k < FLAG_N; k++) begin : g_mask
        assign masked[k] = isr.flags[k] & irq_en_i[k];
    end
    assign irq_o = |masked;
endmodule

// File: tb/nic_irq_status_bench.sv
module nic_irq_status_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_addr = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic start_cmd = 0, tx_cmd = 0, wake = 0, rdma_done = 0, ring_ovw = 0;
    logic [2:0] tally_msb = '0;
    logic tx_excess = 0, tx_oversize = 0, tx_late = 0;
    logic rx_crc = 0, rx_align = 0, rx_missed = 0, tx_ok = 0, rx_ok = 0, col = 0;
    logic [6:0] irq_en = '0;
    logic irq;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    nic_irq_status u_nic_irq_status (
        .clk(clk), .rst_n(rst_n), .host_addr_i(host_addr), .host_wr_i(host_wr),
        .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .start_cmd_i(start_cmd),
        .tx_cmd_i(tx_cmd), .wake_i(wake), .rdma_done_i(rdma_done), .tally_msb_i(tally_msb),
        .ring_ovw_i(ring_ovw), .tx_excess_col_i(tx_excess), .tx_oversize_i(tx_oversize),
        .tx_late_col_i(tx_late), .rx_crc_err_i(rx_crc), .rx_align_err_i(rx_align),
        .rx_missed_i(rx_missed), .tx_ok_i(tx_ok), .rx_ok_i(rx_ok), .col_i(col),
        .irq_en_i(irq_en), .irq_o(irq)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic clear_pulses();
        start_cmd = 0; tx_cmd = 0; wake = 0; rdma_done = 0; ring_ovw = 0;
        tx_excess = 0; tx_oversize = 0; tx_late = 0; rx_crc = 0; rx_align = 0;
        rx_missed = 0; tx_ok = 0; rx_ok = 0; col = 0; host_wr = 0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        host_addr = a; #1; v = host_rdata;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1; cyc(); host_wr = 0;
    endtask

    task automatic pulse_evt(input int k);
        case (k)
            6: rdma_done = 1;
            5: tally_msb[0] = 1;
            4: ring_ovw = 1;
            3: tx_oversize = 1;
            2: rx_crc = 1;
            1: tx_ok = 1;
            default: rx_ok = 1;
        endcase
        cyc(); clear_pulses(); tally_msb = '0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(0, v); chk("R1 isr", v, 8'h80);
        rd(1, v); chk("R1 col", v, 8'h00);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_rst_bit();
        logic [7:0] v;
        wr(0, 8'h80); rd(0, v); chk("R3 write one", v, 8'h80);
        wr(0, 8'h00); rd(0, v); chk("R3 write zero", v, 8'h80);
        start_cmd = 1; cyc(); clear_pulses(); rd(0, v); chk("R2 start clears", v, 8'h00);
        wr(0, 8'h80); rd(0, v); chk("R3 no set by write", v, 8'h00);
        wake = 1; cyc(); clear_pulses(); rd(0, v); chk("R2 wake sets", v, 8'h80);
        wake = 1; start_cmd = 1; cyc(); clear_pulses(); rd(0, v); chk("R2 both same cycle", v, 8'h80);
        start_cmd = 1; cyc(); clear_pulses(); rd(0, v); chk("R2 start again", v, 8'h00);
    endtask

    task automatic t_flags();
        logic [7:0] v;
        irq_en = 7'h7F;
        for (int k = 0; k < 7; k++) begin
            pulse_evt(k);
            rd(0, v); chk($sformatf("R4 bit %0d set", k), v, 1 << k);
            chk("R11 irq on", irq, 1);
            wr(0, 8'h00); rd(0, v); chk("R4 write zero keeps", v, 1 << k);
            wr(0, 8'(1 << k)); rd(0, v); chk("R4 write one clears", v, 8'h00);
        end
        irq_en = '0;
    endtask

    task automatic t_sources();
        logic [7:0] v;
        for (int s = 0; s < 6; s++) begin
            case (s)
                0: tx_excess = 1;
                1: tx_oversize = 1;
                2: tx_late = 1;
                3: rx_crc = 1;
                4: rx_align = 1;
                default: rx_missed = 1;
            endcase
            cyc(); clear_pulses();
            rd(0, v); chk($sformatf("R7 source %0d", s), v, (s < 3) ? 8'h08 : 8'h04);
            wr(0, 8'h7F);
        end
    endtask

    task automatic t_tally();
        logic [7:0] v;
        tally_msb = 3'b010; cyc(); rd(0, v); chk("R6 rise sets", v, 8'h20);
        wr(0, 8'h20); cyc(); cyc(); rd(0, v); chk("R6 steady high no reset", v, 8'h00);
        tally_msb = 3'b110; cyc(); rd(0, v); chk("R6 second rise", v, 8'h20);
        tally_msb = '0; wr(0, 8'h20);
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        tx_ok = 1; cyc(); clear_pulses();
        rx_ok = 1; cyc(); clear_pulses();
        rx_ok = 1; host_addr = 0; host_wdata = 8'h03; host_wr = 1; cyc(); clear_pulses();
        rd(0, v); chk("R5 set beats clear", v, 8'h01);
        wr(0, 8'h01);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        rx_ok = 1; ring_ovw = 1; cyc(); clear_pulses();
        irq_en = '0; #1; chk("R11 all masked", irq, 0);
        irq_en = 7'h10; #1; chk("R11 bit4 enabled", irq, 1);
        irq_en = 7'h40; #1; chk("R11 other bit only", irq, 0);
        wr(0, 8'h7F); wake = 1; cyc(); clear_pulses();
        irq_en = 7'h7F; #1; rd(0, v); chk("R11 bit7 set", v, 8'h80);
        chk("R11 bit7 no irq", irq, 0);
        irq_en = '0;
    endtask

    task automatic t_col();
        logic [7:0] v;
        tx_cmd = 1; cyc(); clear_pulses(); rd(1, v); chk("R10 tx cmd zero", v, 0);
        cyc(); rd(1, v); chk("R8 no collisions", v, 0);
        for (int i = 0; i < 3; i++) begin col = 1; cyc(); clear_pulses(); end
        rd(1, v); chk("R8 three", v, 3);
        for (int i = 0; i < 20; i++) begin col = 1; cyc(); clear_pulses(); end
        rd(1, v); chk("R8 saturate, upper zero", v, 8'h0F);
        tx_cmd = 1; col = 1; cyc(); clear_pulses(); rd(1, v); chk("R10 clear beats col", v, 0);
        for (int i = 0; i < 5; i++) begin col = 1; cyc(); clear_pulses(); end
        rd(1, v); chk("R8 five", v, 5);
        tx_excess = 1; col = 1; cyc(); clear_pulses(); rd(1, v); chk("R9 abort zero", v, 0);
        rd(0, v); chk("R7 abort sets txe", v, 8'h88);
        wr(0, 8'h7F);
        col = 1; cyc(); col = 1; cyc(); clear_pulses();
        wr(1, 8'hFF); rd(1, v); chk("R10 write ignored", v, 2);
        wr(1, 8'h00); rd(1, v); chk("R10 write zero ignored", v, 2);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        clear_pulses();
        #23 rst_n = 1'b1;
        cyc();
        t_reset();
        t_rst_bit();
        t_flags();
        t_sources();
        t_tally();
        t_set_wins();
        t_irq();
        t_col();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule